// File: doc/BRIEF.md
# Descriptor-Table Scatter-Gather DMA Walker

This block is the engine of a bus-master DMA channel. It moves a requested number of bytes between a local data buffer and system memory. The memory side is described by a table of 8-byte descriptors. Each descriptor holds a 32-bit region address in its low word and a size/flags word in its high word. The walker fetches descriptors one at a time through a memory-read request port and decodes each one. It then issues bursts to the data port, and the `dir_write` input, latched at start, sets their direction. While bursting, it advances the region address, the bytes left in the descriptor and the offset into the local buffer.

Software-side logic first pulses `restart` to load the table pointer from `table_base`. It then pulses `start` with a byte count and a direction. When the walk ends, `done` pulses for one cycle and `complete` tells whether every requested byte was moved (1) or the table ran out first (0). A later `start` without a `restart` continues with the descriptor after the last one fetched. A second stretch of buffer can therefore be served from the same table.

Top module: `prd_dma_walker`

## Requirements
- R1: While `rst_n` is low at a clock edge, the walker returns to idle: `busy`, `done`, `desc_req_valid` and `xfer_valid` are 0 and all progress state is cleared.
- R2: A descriptor is requested at the current table pointer, and the pointer advances by 8 on each accepted request. A fetch happens only when the bytes left in the current descriptor are zero and requested bytes remain, and never while a burst is offered.
- R3: A descriptor's region address is bits 31:0 of the 64-bit response. Its byte length is bits 47:32 ANDed with 0xFFFE, so bit 32 of the response (size bit 0) has no effect.
- R4: A masked length of zero is taken as 65536 bytes.
- R5: Bit 63 of the response (size bit 31) marks the final descriptor. Once it is exhausted while bytes are still requested, the walk ends with `complete` = 0.
- R6: No descriptor is requested once the pointer is PAGE_BYTES or more past the base loaded by the last restart. The walk then ends with `complete` = 0.
- R7: Each burst length is the smallest of the requested bytes left, the descriptor bytes left and MAX_BURST. Its address is the descriptor's current address, and `xfer_buf_off` is the number of bytes already moved. Offered bursts hold their fields until accepted.
- R8: `xfer_write` equals the `dir_write` value sampled with `start`, for the whole walk.
- R9: When the walk ends, `done` is high for exactly one cycle with `complete` = 1 if all requested bytes were moved. A request of zero bytes completes without any fetch or burst.
- R10: `restart` reloads the table pointer from `table_base`. `start` discards the current descriptor's address, remaining length and final flag, but keeps the pointer.
- R11: `start` and `restart` are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk (idle only) |
| restart | input | 1 | Reload table pointer and base from `table_base` (idle only) |
| dir_write | input | 1 | Burst direction for the walk, 1 = write to memory |
| req_bytes | input | REQ_W | Bytes the local buffer needs moved |
| table_base | input | 32 | Descriptor table base address |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| complete | output | 1 | Outcome of last walk: 1 all moved, 0 table exhausted |
| desc_req_valid | output | 1 | Descriptor read request |
| desc_req_ready | input | 1 | Descriptor read request accepted |
| desc_req_addr | output | 32 | Descriptor address |
| desc_rsp_valid | input | 1 | Descriptor data valid |
| desc_rsp_data | input | 64 | Descriptor, little-endian: address low, size/flags high |
| xfer_valid | output | 1 | Burst offered |
| xfer_ready | input | 1 | Burst accepted |
| xfer_write | output | 1 | Burst direction |
| xfer_addr | output | 32 | Burst memory address |
| xfer_len | output | BURST_W | Burst length in bytes |
| xfer_buf_off | output | REQ_W | Local buffer offset of the burst |

## Verification
The bench builds the walker with MAX_BURST = 16 and PAGE_BYTES = 32, and keeps REQ_W at 20. The small burst limit turns every descriptor of a few dozen bytes into several bursts, so chunk splitting and address advance are observed often. A 64 KiB zero-length descriptor can then be recognised by its first bursts alone. The 32-byte page makes the failsafe stop fire after four fetches on a table that has no final flag. Both ready signals stall in irregular patterns, which tests that offered requests are held.

// File: rtl/prd_dma_pkg.sv
// Shared types for the descriptor-table DMA walker.
package prd_dma_pkg;

    localparam int DESC_BYTES = 8;   // size of one table entry
    localparam int DLEN_W     = 17;  // descriptor length, up to 65536

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FREQ,
        ST_FWAIT,
        ST_XFER,
        ST_DONE
    } walk_state_t;

endpackage

// File: rtl/prd_desc_decode.sv
// Splits a fetched 64-bit descriptor into region address, byte length
// and final-entry flag. Assumes little-endian packing: address word in
// bits 31:0, size/flags word in bits 63:32.
module prd_desc_decode
    import prd_dma_pkg::*;
(
    input  logic [63:0]       desc,
    output logic [31:0]       region_addr,
    output logic [DLEN_W-1:0] region_len,
    output logic              region_final
);

    logic [31:0] size_masked;

    // length keeps bits 15:1 of the size word; zero stands for 64 KiB
    assign size_masked  = desc[63:32] & 32'h0000_FFFE;
    assign region_len   = (size_masked == 32'd0) ? DLEN_W'(17'h10000)
                                                 : size_masked[DLEN_W-1:0];
    assign region_addr  = desc[31:0];
    assign region_final = desc[63];

endmodule

// File: rtl/prd_burst_size.sv
// Picks the next burst length: smallest of bytes still requested, bytes
// left in the descriptor and the burst ceiling. Assumes both remaining
// counts fit in 32 bits.
module prd_burst_size
    import prd_dma_pkg::*;
#(
    parameter int REQ_W     = 20,
    parameter int MAX_BURST = 256,
    localparam int BURST_W  = $clog2(MAX_BURST + 1)
) (
    input  logic [REQ_W-1:0]  rem_req,
    input  logic [DLEN_W-1:0] rem_desc,
    output logic [BURST_W-1:0] burst
);

    logic [31:0] a_req, a_desc, a_min;

    // two-stage minimum with the ceiling applied last
    always_comb begin
        a_req  = 32'(rem_req);
        a_desc = 32'(rem_desc);
        a_min  = (a_req < a_desc) ? a_req : a_desc;
        if (a_min > 32'(MAX_BURST)) a_min = 32'(MAX_BURST);
        burst  = BURST_W'(a_min);
    end

endmodule

// File: rtl/prd_dma_walker.sv
// Descriptor-table walker: fetches 8-byte descriptors from the table
// pointer, splits each region into bursts and reports whether the
// requested bytes were all moved. Assumes one descriptor response per
// accepted request, delivered after acceptance; a burst counts as moved
// when accepted.
module prd_dma_walker
    import prd_dma_pkg::*;
#(
    parameter int REQ_W      = 20,
    parameter int MAX_BURST  = 256,
    parameter int PAGE_BYTES = 4096,
    localparam int BURST_W   = $clog2(MAX_BURST + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               restart,
    input  logic               dir_write,
    input  logic [REQ_W-1:0]   req_bytes,
    input  logic [31:0]        table_base,
    output logic               busy,
    output logic               done,
    output logic               complete,
    output logic               desc_req_valid,
    input  logic               desc_req_ready,
    output logic [31:0]        desc_req_addr,
    input  logic               desc_rsp_valid,
    input  logic [63:0]        desc_rsp_data,
    output logic               xfer_valid,
    input  logic               xfer_ready,
    output logic               xfer_write,
    output logic [31:0]        xfer_addr,
    output logic [BURST_W-1:0] xfer_len,
    output logic [REQ_W-1:0]   xfer_buf_off
);

    walk_state_t       state;
    logic [31:0]       cur_ptr, tbl_base, cur_addr;
    logic [DLEN_W-1:0] cur_len;
    logic              cur_last;
    logic [REQ_W-1:0]  rem_req, buf_off;
    logic              run_dir, outcome;

    logic [31:0]       dec_addr;
    logic [DLEN_W-1:0] dec_len;
    logic              dec_last;
    logic [BURST_W-1:0] burst;
    logic              page_hit;

    prd_desc_decode u_decode (
        .desc         (desc_rsp_data),
        .region_addr  (dec_addr),
        .region_len   (dec_len),
        .region_final (dec_last)
    );

    prd_burst_size #(
        .REQ_W     (REQ_W),
        .MAX_BURST (MAX_BURST)
    ) u_size (
        .rem_req  (rem_req),
        .rem_desc (cur_len),
        .burst    (burst)
    );

    // failsafe: table pointer has walked a page past the base
    assign page_hit = (cur_ptr - tbl_base) >= 32'(PAGE_BYTES);

    // walk sequencer and progress counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_ptr  <= '0;
            tbl_base <= '0;
            cur_addr <= '0;
            cur_len  <= '0;
            cur_last <= 1'b0;
            rem_req  <= '0;
            buf_off  <= '0;
            run_dir  <= 1'b0;
            outcome  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (restart) begin
                        cur_ptr  <= table_base;
                        tbl_base <= table_base;
                    end
                    if (start) begin
                        rem_req  <= req_bytes;
                        buf_off  <= '0;
                        run_dir  <= dir_write;
                        cur_addr <= '0;
                        cur_len  <= '0;
                        cur_last <= 1'b0;
                        state    <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (rem_req == '0) begin
                        outcome <= 1'b1;
                        state   <= ST_DONE;
                    end else if (cur_len != '0) begin
                        state <= ST_XFER;
                    end else if (cur_last || page_hit) begin
                        outcome <= 1'b0;
                        state   <= ST_DONE;
                    end else begin
                        state <= ST_FREQ;
                    end
                end
                ST_FREQ: begin
                    if (desc_req_ready) begin
                        cur_ptr <= cur_ptr + 32'(DESC_BYTES);
                        state   <= ST_FWAIT;
                    end
                end
                ST_FWAIT: begin
                    if (desc_rsp_valid) begin
                        cur_addr <= dec_addr;
                        cur_len  <= dec_len;
                        cur_last <= dec_last;
                        state    <= ST_CHECK;
                    end
                end
                ST_XFER: begin
                    if (xfer_ready) begin
                        cur_addr <= cur_addr + 32'(burst);
                        cur_len  <= cur_len - DLEN_W'(burst);
                        rem_req  <= rem_req - REQ_W'(burst);
                        buf_off  <= buf_off + REQ_W'(burst);
                        state    <= ST_CHECK;
                    end
                end
                ST_DONE:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // port view of the sequencer
    assign busy           = (state != ST_IDLE);
    assign done           = (state == ST_DONE);
    assign complete       = outcome;
    assign desc_req_valid = (state == ST_FREQ);
    assign desc_req_addr  = cur_ptr;
    assign xfer_valid     = (state == ST_XFER);
    assign xfer_write     = run_dir;
    assign xfer_addr      = cur_addr;
    assign xfer_len       = burst;
    assign xfer_buf_off   = buf_off;

endmodule

// File: rtl/prd_dma_walker_chk.sv
// Protocol and limit checks for the walker, bound to every instance.
module prd_dma_walker_chk #(
    parameter int REQ_W      = 20,
    parameter int MAX_BURST  = 256,
    parameter int PAGE_BYTES = 4096,
    localparam int BURST_W   = $clog2(MAX_BURST + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               done,
    input logic               desc_req_valid,
    input logic               desc_req_ready,
    input logic [31:0]        desc_req_addr,
    input logic               xfer_valid,
    input logic               xfer_ready,
    input logic               xfer_write,
    input logic [31:0]        xfer_addr,
    input logic [BURST_W-1:0] xfer_len,
    input logic [REQ_W-1:0]   xfer_buf_off,
    input logic [31:0]        tbl_base
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !busy && !xfer_valid && !desc_req_valid); // R1

    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        desc_req_valid && !desc_req_ready |=> desc_req_valid && $stable(desc_req_addr)); // R2

    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        !(desc_req_valid && xfer_valid)); // R2

    AST_PAGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        desc_req_valid |-> (desc_req_addr - tbl_base) < 32'(PAGE_BYTES)); // R6

    AST_BURST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> xfer_len != '0 && 32'(xfer_len) <= 32'(MAX_BURST)); // R7

    AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr)
            && $stable(xfer_len) && $stable(xfer_buf_off)); // R7

    AST_DIR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> $stable(xfer_write)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy); // R9

endmodule

bind prd_dma_walker prd_dma_walker_chk #(
    .REQ_W      (REQ_W),
    .MAX_BURST  (MAX_BURST),
    .PAGE_BYTES (PAGE_BYTES)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .busy           (busy),
    .done           (done),
    .desc_req_valid (desc_req_valid),
    .desc_req_ready (desc_req_ready),
    .desc_req_addr  (desc_req_addr),
    .xfer_valid     (xfer_valid),
    .xfer_ready     (xfer_ready),
    .xfer_write     (xfer_write),
    .xfer_addr      (xfer_addr),
    .xfer_len       (xfer_len),
    .xfer_buf_off   (xfer_buf_off),
    .tbl_base       (tbl_base)
);

// File: tb/prd_dma_walker_tb.sv
`timescale 1ns/1ps
module prd_dma_walker_tb;

    localparam int REQ_W = 20;
    localparam int MAXB  = 16;
    localparam int PAGE  = 32;
    localparam int BW    = $clog2(MAXB + 1);

    typedef struct packed {
        logic [31:0]      a;
        logic [BW-1:0]    l;
        logic             w;
        logic [REQ_W-1:0] o;
    } burst_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0, restart = 1'b0, dir_write = 1'b0;
    logic [REQ_W-1:0] req_bytes = '0;
    logic [31:0]      table_base = '0;
    logic             busy, done, complete;
    logic             desc_req_valid, desc_req_ready = 1'b0;
    logic [31:0]      desc_req_addr;
    logic             desc_rsp_valid = 1'b0;
    logic [63:0]      desc_rsp_data = '0;
    logic             xfer_valid, xfer_ready = 1'b0, xfer_write;
    logic [31:0]      xfer_addr;
    logic [BW-1:0]    xfer_len;
    logic [REQ_W-1:0] xfer_buf_off;

    always #2.5 clk = ~clk;

    prd_dma_walker #(.REQ_W(REQ_W), .MAX_BURST(MAXB), .PAGE_BYTES(PAGE)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .restart(restart),
        .dir_write(dir_write), .req_bytes(req_bytes), .table_base(table_base),
        .busy(busy), .done(done), .complete(complete),
        .desc_req_valid(desc_req_valid), .desc_req_ready(desc_req_ready),
        .desc_req_addr(desc_req_addr), .desc_rsp_valid(desc_rsp_valid),
        .desc_rsp_data(desc_rsp_data), .xfer_valid(xfer_valid),
        .xfer_ready(xfer_ready), .xfer_write(xfer_write), .xfer_addr(xfer_addr),
        .xfer_len(xfer_len), .xfer_buf_off(xfer_buf_off)
    );

    int          n_checks = 0, n_fail = 0;
    logic [63:0] desc_mem [0:7];
    burst_t      xq[$];
    logic [31:0] fq[$];
    logic [31:0] m_ptr = '0, m_base = '0;
    bit          exp_complete = 1'b0, done_flag = 1'b0, pend = 1'b0;
    logic [31:0] pend_addr = '0;
    int          rc = 0;

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // reference walk built from the requirements; fills the scoreboard
    task automatic model_run(int req, bit dir);
        int rem = req, clen = 0, off = 0, b;
        bit last = 1'b0;
        logic [31:0] caddr = '0;
        logic [63:0] d;
        logic [31:0] sz;
        forever begin
            if (rem == 0) begin exp_complete = 1'b1; break; end
            if (clen == 0) begin
                if (last || (m_ptr - m_base) >= 32'(PAGE)) begin
                    exp_complete = 1'b0; break;
                end
                fq.push_back(m_ptr);
                d = desc_mem[((m_ptr - m_base) >> 3) & 7];
                m_ptr = m_ptr + 8;
                sz    = d[63:32] & 32'h0000_FFFE;
                clen  = (sz == 0) ? 65536 : int'(sz);
                caddr = d[31:0];
                last  = d[63];
            end else begin
                b = (rem < clen) ? rem : clen;
                if (b > MAXB) b = MAXB;
                xq.push_back('{a: caddr, l: BW'(b), w: dir, o: REQ_W'(off)});
                caddr = caddr + 32'(b);
                clen -= b; rem -= b; off += b;
            end
        end
    endtask

    // monitor and memory responder, evaluated between clock edges
    always @(negedge clk) begin
        burst_t e;
        logic [31:0] fa;
        if (rst_n) begin
            xfer_ready = (rc % 3) != 0;
            if (xfer_valid && xfer_ready) begin
                if (xq.size() == 0) begin
                    check(1'b0, "R7", "unexpected burst addr", 64'(xfer_addr), 64'h0);
                end else begin
                    e = xq.pop_front();
                    check(xfer_addr == e.a && xfer_len == e.l && xfer_buf_off == e.o,
                          "R7", "burst addr/len/off", {xfer_addr, 7'd0, xfer_len, 7'd0, xfer_buf_off},
                          {e.a, 7'd0, e.l, 7'd0, e.o});
                    check(xfer_write == e.w, "R8", "burst direction", 64'(xfer_write), 64'(e.w));
                end
            end
            if (desc_rsp_valid) desc_rsp_valid = 1'b0;
            if (pend) begin
                desc_rsp_valid = 1'b1;
                desc_rsp_data  = desc_mem[((pend_addr - m_base) >> 3) & 7];
                pend = 1'b0;
            end
            desc_req_ready = (rc % 4) != 1;
            if (desc_req_valid && desc_req_ready) begin
                fa = (fq.size() != 0) ? fq.pop_front() : 32'hFFFF_FFFF;
                check(desc_req_addr == fa, "R2", "descriptor fetch address",
                      64'(desc_req_addr), 64'(fa));
                pend = 1'b1;
                pend_addr = desc_req_addr;
            end
            if (done) begin
                check(complete == exp_complete, "R9", "outcome flag",
                      64'(complete), 64'(exp_complete));
                check(xq.size() == 0 && fq.size() == 0, "R9", "leftover expected items",
                      64'(xq.size() + fq.size()), 64'h0);
                done_flag = 1'b1;
            end
            rc++;
        end
    end

    task automatic run_case(int req, bit dir, bit do_restart, logic [31:0] base, bit poke);
        int cyc = 0;
        @(negedge clk);
        if (do_restart) begin
            restart = 1'b1; table_base = base;
            @(negedge clk);
            restart = 1'b0;
            m_ptr = base; m_base = base;
        end
        model_run(req, dir);
        done_flag = 1'b0;
        req_bytes = REQ_W'(req); dir_write = dir; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R11: commands during a walk must not disturb it
            repeat (3) @(negedge clk);
            start = 1'b1; restart = 1'b1; req_bytes = 7;
            dir_write = ~dir; table_base = base + 64;
            @(negedge clk);
            start = 1'b0; restart = 1'b0;
        end
        while (!done_flag && cyc < 3000) begin @(negedge clk); cyc++; end
        if (!done_flag) check(1'b0, "R9", "walk never ended", 64'h0, 64'h1);
        @(negedge clk);
    endtask

    initial begin
        repeat (1000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog: actual=timeout expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) desc_mem[i] = '0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !xfer_valid && !desc_req_valid, "R1", "idle after reset",
              {60'h0, busy, done, xfer_valid, desc_req_valid}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R7 R8: odd size bit ignored, bursts split at the ceiling
        desc_mem[0] = {32'h0000_0028, 32'h0000_2000};
        desc_mem[1] = {32'h8000_0019, 32'h0000_3000};
        run_case(60, 1'b1, 1'b1, 32'h1000, 1'b0);
        // R5: final entry runs out before 100 bytes
        run_case(100, 1'b0, 1'b1, 32'h1000, 1'b0);

        // R4: zero length means 64 KiB; R11 poke during walk
        desc_mem[0] = {32'h8000_0001, 32'h0000_4000};
        run_case(50, 1'b1, 1'b1, 32'h1000, 1'b1);

        // R6: page failsafe after four 8-byte entries; R11 poke again
        for (int i = 0; i < 8; i++) desc_mem[i] = {32'h0000_0008, 32'h0000_5000 + 32'(i) * 32'h100};
        run_case(100, 1'b0, 1'b1, 32'h1000, 1'b1);

        // R10: start drops leftover length, pointer continues; restart rewinds
        desc_mem[0] = {32'h0000_0010, 32'h0000_6000};
        desc_mem[1] = {32'h8000_0010, 32'h0000_7000};
        run_case(10, 1'b1, 1'b1, 32'h1000, 1'b0);
        run_case(16, 1'b1, 1'b0, 32'h1000, 1'b0);
        run_case(4,  1'b0, 1'b1, 32'h1000, 1'b0);

        // R9: zero-byte request completes with no traffic
        run_case(0, 1'b1, 1'b0, 32'h1000, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule